// File: doc/BRIEF.md
# Byte/Word Effective-Address Unit

This unit forms the data-memory address for one load or store on a 16-bit datapath. Addresses count bytes, not words. Each request brings a base register value, an addressing mode, a byte-or-word size flag and a read-or-write flag. One cycle later the unit presents a memory strobe with the effective address, the byte enables and the write data lined up with the byte lanes. In the same cycle it offers the updated base value for write-back to the register file.

The step added to or subtracted from the base grows with the operand size: one for a byte and the lane count for a word. The low address bit picks the byte lane, so that a byte read fetches the whole word and returns only the selected byte. A word access at an odd effective address is never split into two accesses. Instead the unit raises a one-cycle trap and withholds both the memory strobe and the register write-back, so that the machine state is exactly what it was before the faulting access.

Top module: `ea_unit`

## Requirements
- R1: While `rst` is high, and in the cycle after a reset edge, `mem_strobe`, `trap`, `reg_wb_en` and `rd_valid` are all 0.
- R2: The mode code on `req_mode` is 0 = plain, 1 = post-increment, 2 = post-decrement, 3 = pre-increment, 4 = pre-decrement, and codes 5 to 7 act as plain. Plain and post modes use the base as the effective address (`mem_addr`). Pre modes use the modified value.
- R3: The step is 1 for a byte access and 2 for a word access, in both directions. Modifying modes present the modified value on `reg_wb_val` with `reg_wb_en` = 1. Plain mode leaves `reg_wb_en` at 0.
- R4: All address arithmetic wraps modulo 2^16 (0xFFFF + 1 = 0x0000, 0x0000 - 1 = 0xFFFF).
- R5: A word access whose effective address has bit 0 set raises `trap` for one cycle, with `mem_strobe` = 0 and `reg_wb_en` = 0 in that cycle.
- R6: `mem_be` bit 0 is the low byte (data bits 7:0) and bit 1 is the high byte (bits 15:8). A byte access drives only the bit chosen by address bit 0 (0 selects low, 1 selects high). A word access drives both bits.
- R7: On a byte write, `req_wdata[7:0]` appears on every byte lane of `mem_wdata`. On a word write, `mem_wdata` equals `req_wdata`.
- R8: `rd_valid` is 1 exactly one cycle after a read strobe. In that cycle `rd_data` is the full `mem_rdata` for a word read, or the selected byte zero-extended for a byte read (lane 0 = bits 7:0, lane 1 = bits 15:8). Otherwise `rd_data` is 0.
- R9: Every access output is registered. The strobe, trap and write-back appear one cycle after `req_valid` and never without it.
- R10: Byte accesses never trap, at odd and even addresses alike.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_mode | input | 3 | Addressing mode code |
| req_byte | input | 1 | 1 = byte access, 0 = word access |
| req_write | input | 1 | 1 = store, 0 = load |
| req_base | input | ADDR_W | Base register value |
| req_wdata | input | DATA_W | Store data |
| mem_strobe | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Effective byte address |
| mem_be | output | DATA_W/8 | Byte-lane enables |
| mem_wdata | output | DATA_W | Lane-aligned store data |
| mem_rdata | input | DATA_W | Word returned by memory the cycle after a read strobe |
| reg_wb_en | output | 1 | Base register write-back enable |
| reg_wb_val | output | ADDR_W | Updated base value |
| trap | output | 1 | Misaligned word access fault |
| rd_valid | output | 1 | Load result valid |
| rd_data | output | DATA_W | Load result |

## Verification
The bench builds the unit with its default widths: a 16-bit address and a 16-bit data word, which gives two byte lanes and a step of 2 for a word. With those values it can reach both ends of the address space, so it checks increments and decrements that cross 0xFFFF/0x0000. It also drives odd word addresses that exist only after a pre-modify, or only before a post-modify, and both lanes for byte reads and writes. Back-to-back requests and a reset in the middle of a request cover the registered timing.

// File: rtl/eau_pkg.sv
package eau_pkg;

    typedef enum logic [2:0] {
        AM_PLAIN    = 3'd0,
        AM_POST_INC = 3'd1,
        AM_POST_DEC = 3'd2,
        AM_PRE_INC  = 3'd3,
        AM_PRE_DEC  = 3'd4
    } am_mode_e;

    // Unused codes fall back to plain indirect.
    function automatic am_mode_e decode_mode(input logic [2:0] code);
        case (code)
            3'd1:    return AM_POST_INC;
            3'd2:    return AM_POST_DEC;
            3'd3:    return AM_PRE_INC;
            3'd4:    return AM_PRE_DEC;
            default: return AM_PLAIN;
        endcase
    endfunction

    function automatic logic mode_modifies(input am_mode_e m);
        return m != AM_PLAIN;
    endfunction

    function automatic logic mode_is_pre(input am_mode_e m);
        return (m == AM_PRE_INC) || (m == AM_PRE_DEC);
    endfunction

    function automatic logic mode_goes_down(input am_mode_e m);
        return (m == AM_POST_DEC) || (m == AM_PRE_DEC);
    endfunction

endpackage

// File: rtl/eau_addr_calc.sv
module eau_addr_calc #(
    parameter int ADDR_W = 16,
    parameter int LANES  = 2
) (
    input  logic [2:0]        mode_code,
    input  logic              byte_op,
    input  logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] ea,
    output logic [ADDR_W-1:0] upd,
    output logic              wb_en,
    output logic              misalign
);
    import eau_pkg::*;

    localparam int LANE_W = $clog2(LANES);

    am_mode_e          mode;
    logic [ADDR_W-1:0] step;
    logic [ADDR_W-1:0] moved;

    always_comb begin
        mode  = decode_mode(mode_code);
        step  = byte_op ? ADDR_W'(1) : ADDR_W'(LANES);
        // Natural-width arithmetic wraps modulo 2^ADDR_W.
        moved = mode_goes_down(mode) ? (base - step) : (base + step);
        upd   = moved;
        wb_en = mode_modifies(mode);
        ea    = mode_is_pre(mode) ? moved : base;
        misalign = !byte_op && (ea[LANE_W-1:0] != '0);
    end

endmodule

// File: rtl/eau_lane_ctl.sv
module eau_lane_ctl #(
    parameter int DATA_W = 16,
    parameter int LANES  = DATA_W / 8
) (
    input  logic                     byte_op,
    input  logic [$clog2(LANES)-1:0] lane,
    input  logic [DATA_W-1:0]        wdata_in,
    output logic [LANES-1:0]         be,
    output logic [DATA_W-1:0]        wdata_out
);
    localparam int LANE_W = $clog2(LANES);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign be[i] = !byte_op || (lane == LANE_W'(i));
        assign wdata_out[i*8 +: 8] = byte_op ? wdata_in[7:0] : wdata_in[i*8 +: 8];
    end

endmodule

// File: rtl/eau_rd_extract.sv
module eau_rd_extract #(
    parameter int DATA_W = 16,
    parameter int LANES  = DATA_W / 8
) (
    input  logic                     byte_op,
    input  logic [$clog2(LANES)-1:0] lane,
    input  logic [DATA_W-1:0]        word_in,
    output logic [DATA_W-1:0]        data_out
);
    localparam int LANE_W = $clog2(LANES);

    logic [7:0] sel;

    always_comb begin
        sel = '0;
        for (int i = 0; i < LANES; i++) begin
            if (lane == LANE_W'(i)) sel = word_in[i*8 +: 8];
        end
        data_out = byte_op ? {{(DATA_W-8){1'b0}}, sel} : word_in;
    end

endmodule

// File: rtl/ea_unit.sv
module ea_unit #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic [2:0]            req_mode,
    input  logic                  req_byte,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_base,
    input  logic [DATA_W-1:0]     req_wdata,
    output logic                  mem_strobe,
    output logic                  mem_we,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [DATA_W/8-1:0]   mem_be,
    output logic [DATA_W-1:0]     mem_wdata,
    input  logic [DATA_W-1:0]     mem_rdata,
    output logic                  reg_wb_en,
    output logic [ADDR_W-1:0]     reg_wb_val,
    output logic                  trap,
    output logic                  rd_valid,
    output logic [DATA_W-1:0]     rd_data
);
    localparam int LANES  = DATA_W / 8;
    localparam int LANE_W = $clog2(LANES);

    typedef struct packed {
        logic              strobe;
        logic              we;
        logic              byte_op;
        logic [ADDR_W-1:0] addr;
        logic [LANES-1:0]  be;
        logic [DATA_W-1:0] wdata;
        logic              wb_en;
        logic [ADDR_W-1:0] wb_val;
        logic              trap;
    } acc_stage_t;

    typedef struct packed {
        logic              valid;
        logic              byte_op;
        logic [LANE_W-1:0] lane;
    } rd_stage_t;

    logic [ADDR_W-1:0] ea_c;
    logic [ADDR_W-1:0] upd_c;
    logic              wb_c;
    logic              mis_c;
    logic [LANES-1:0]  be_c;
    logic [DATA_W-1:0] wd_c;
    logic [DATA_W-1:0] ext_c;

    acc_stage_t acc_nxt, acc_q;
    rd_stage_t  rd_q;

    eau_addr_calc #(.ADDR_W(ADDR_W), .LANES(LANES)) u_calc (
        .mode_code (req_mode),
        .byte_op   (req_byte),
        .base      (req_base),
        .ea        (ea_c),
        .upd       (upd_c),
        .wb_en     (wb_c),
        .misalign  (mis_c)
    );

    eau_lane_ctl #(.DATA_W(DATA_W), .LANES(LANES)) u_lanes (
        .byte_op   (req_byte),
        .lane      (ea_c[LANE_W-1:0]),
        .wdata_in  (req_wdata),
        .be        (be_c),
        .wdata_out (wd_c)
    );

    always_comb begin
        acc_nxt.strobe  = req_valid && !mis_c;
        acc_nxt.we      = req_write;
        acc_nxt.byte_op = req_byte;
        acc_nxt.addr    = ea_c;
        acc_nxt.be      = (req_valid && !mis_c) ? be_c : '0;
        acc_nxt.wdata   = wd_c;
        acc_nxt.wb_en   = req_valid && !mis_c && wb_c;
        acc_nxt.wb_val  = upd_c;
        acc_nxt.trap    = req_valid && mis_c;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            rd_q  <= '0;
        end else begin
            acc_q         <= acc_nxt;
            rd_q.valid    <= acc_q.strobe && !acc_q.we;
            rd_q.byte_op  <= acc_q.byte_op;
            rd_q.lane     <= acc_q.addr[LANE_W-1:0];
        end
    end

    eau_rd_extract #(.DATA_W(DATA_W), .LANES(LANES)) u_extract (
        .byte_op  (rd_q.byte_op),
        .lane     (rd_q.lane),
        .word_in  (mem_rdata),
        .data_out (ext_c)
    );

    assign mem_strobe = acc_q.strobe;
    assign mem_we     = acc_q.strobe && acc_q.we;
    assign mem_addr   = acc_q.addr;
    assign mem_be     = acc_q.be;
    assign mem_wdata  = acc_q.wdata;
    assign reg_wb_en  = acc_q.wb_en;
    assign reg_wb_val = acc_q.wb_val;
    assign trap       = acc_q.trap;
    assign rd_valid   = rd_q.valid;
    assign rd_data    = rd_q.valid ? ext_c : '0;

endmodule

// File: rtl/eau_checker.sv
module eau_checker #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input logic                clk,
    input logic                rst,
    input logic                req_valid,
    input logic [2:0]          req_mode,
    input logic                req_byte,
    input logic                mem_strobe,
    input logic                mem_we,
    input logic [ADDR_W-1:0]   mem_addr,
    input logic [DATA_W/8-1:0] mem_be,
    input logic                reg_wb_en,
    input logic                trap,
    input logic                rd_valid
);
    localparam int LANE_W = $clog2(DATA_W / 8);

    // R5: a fault blocks the access and the write-back
    a_r5_trap_blocks_access: assert property (@(posedge clk) disable iff (rst)
        trap |-> (!mem_strobe && !reg_wb_en));

    // R5: any strobe with all lanes enabled sits on an aligned address
    a_r5_word_aligned: assert property (@(posedge clk) disable iff (rst)
        (mem_strobe && (&mem_be)) |-> (mem_addr[LANE_W-1:0] == '0));

    // R9: no strobe without a request in the cycle before
    a_r9_strobe_needs_req: assert property (@(posedge clk) disable iff (rst)
        mem_strobe |-> $past(req_valid));

    // R10: a fault only follows a word request
    a_r10_trap_word_only: assert property (@(posedge clk) disable iff (rst)
        trap |-> ($past(req_valid) && !$past(req_byte)));

    // R6: the enables are either one lane or all lanes
    a_r6_be_shape: assert property (@(posedge clk) disable iff (rst)
        mem_strobe |-> (($countones(mem_be) == 1) || (&mem_be)));

    // R3: write-back only follows a modifying mode code
    a_r3_wb_needs_modify: assert property (@(posedge clk) disable iff (rst)
        reg_wb_en |-> (($past(req_mode) != 3'd0) && ($past(req_mode) < 3'd5)));

    // R8: a load result follows a read strobe
    a_r8_rd_follows_read: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(mem_strobe && !mem_we));

endmodule

bind ea_unit eau_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_eau_checker (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_mode   (req_mode),
    .req_byte   (req_byte),
    .mem_strobe (mem_strobe),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_be     (mem_be),
    .reg_wb_en  (reg_wb_en),
    .trap       (trap),
    .rd_valid   (rd_valid)
);

// File: tb/ea_unit_bench.sv
`timescale 1ns/1ps
module ea_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [2:0]  req_mode = '0;
    logic        req_byte = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_base = '0;
    logic [15:0] req_wdata = '0;
    logic        mem_strobe, mem_we;
    logic [15:0] mem_addr;
    logic [1:0]  mem_be;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        reg_wb_en;
    logic [15:0] reg_wb_val;
    logic        trap, rd_valid;
    logic [15:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    ea_unit u_ea_unit (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(req_mode),
        .req_byte(req_byte), .req_write(req_write), .req_base(req_base),
        .req_wdata(req_wdata), .mem_strobe(mem_strobe), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .reg_wb_en(reg_wb_en), .reg_wb_val(reg_wb_val),
        .trap(trap), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    typedef struct packed {
        logic [2:0]  mode;
        logic        byt;
        logic        wr;
        logic [15:0] base;
        logic [15:0] wdata;
        logic [15:0] rword;
        logic [15:0] ea;
        logic        trp;
        logic        rwe;
        logic [15:0] rnew;
        logic [1:0]  be;
        logic [15:0] wd;
        logic [15:0] rd;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [0:NV-1] = '{
        // plain word read
        '{3'd0,1'b0,1'b0,16'h1000,16'h0000,16'hBEEF,16'h1000,1'b0,1'b0,16'h0000,2'b11,16'h0000,16'hBEEF},
        // post-inc byte read, high lane
        '{3'd1,1'b1,1'b0,16'h2001,16'h0000,16'h12AB,16'h2001,1'b0,1'b1,16'h2002,2'b10,16'h0000,16'h0012},
        // post-inc word read
        '{3'd1,1'b0,1'b0,16'h2000,16'h0000,16'h5555,16'h2000,1'b0,1'b1,16'h2002,2'b11,16'h0000,16'h5555},
        // post-dec byte read, low lane
        '{3'd2,1'b1,1'b0,16'h3000,16'h0000,16'h34CD,16'h3000,1'b0,1'b1,16'h2FFF,2'b01,16'h0000,16'h00CD},
        // pre-dec word write
        '{3'd4,1'b0,1'b1,16'h3004,16'hA5A5,16'h0000,16'h3002,1'b0,1'b1,16'h3002,2'b11,16'hA5A5,16'h0000},
        // pre-inc byte write, high lane
        '{3'd3,1'b1,1'b1,16'h4000,16'h77C3,16'h0000,16'h4001,1'b0,1'b1,16'h4001,2'b10,16'hC3C3,16'h0000},
        // pre-inc word read wrapping to 0
        '{3'd3,1'b0,1'b0,16'hFFFE,16'h0000,16'h0F0F,16'h0000,1'b0,1'b1,16'h0000,2'b11,16'h0000,16'h0F0F},
        // post-dec byte read wrapping to FFFF
        '{3'd2,1'b1,1'b0,16'h0000,16'h0000,16'h8001,16'h0000,1'b0,1'b1,16'hFFFF,2'b01,16'h0000,16'h0001},
        // post-inc word at odd base: trap
        '{3'd1,1'b0,1'b0,16'h1235,16'h0000,16'h0000,16'h0000,1'b1,1'b0,16'h0000,2'b00,16'h0000,16'h0000},
        // pre-inc word write landing odd: trap
        '{3'd3,1'b0,1'b1,16'h0FFF,16'h1111,16'h0000,16'h0000,1'b1,1'b0,16'h0000,2'b00,16'h0000,16'h0000},
        // plain byte write at odd address
        '{3'd0,1'b1,1'b1,16'h5555,16'h00E7,16'h0000,16'h5555,1'b0,1'b0,16'h0000,2'b10,16'hE7E7,16'h0000},
        // code 5 acts as plain
        '{3'd5,1'b0,1'b0,16'h6000,16'h0000,16'hCAFE,16'h6000,1'b0,1'b0,16'h0000,2'b11,16'h0000,16'hCAFE},
        // pre-dec word wrapping to odd FFFF: trap
        '{3'd4,1'b0,1'b0,16'h0001,16'h0000,16'h0000,16'h0000,1'b1,1'b0,16'h0000,2'b00,16'h0000,16'h0000}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] m, input logic b, input logic w,
                         input logic [15:0] base, input logic [15:0] wd);
        req_valid = 1'b1; req_mode = m; req_byte = b; req_write = w;
        req_base = base; req_wdata = wd;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 strobe in reset", mem_strobe, 0);
        chk("R1 trap in reset", trap, 0);
        chk("R1 wb in reset", reg_wb_en, 0);
        chk("R1 rd_valid in reset", rd_valid, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R9 idle no strobe", mem_strobe, 0);

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].mode, VECS[i].byt, VECS[i].wr, VECS[i].base, VECS[i].wdata);
            @(negedge clk);
            req_valid = 1'b0;
            mem_rdata = VECS[i].rword;
            chk($sformatf("R5 trap v%0d", i), trap, VECS[i].trp);
            chk($sformatf("R9 strobe v%0d", i), mem_strobe, !VECS[i].trp);
            chk($sformatf("R3 wb_en v%0d", i), reg_wb_en, VECS[i].rwe);
            if (!VECS[i].trp) begin
                chk($sformatf("R2 R4 ea v%0d", i), mem_addr, VECS[i].ea);
                chk($sformatf("R6 be v%0d", i), mem_be, VECS[i].be);
                chk($sformatf("R9 we v%0d", i), mem_we, VECS[i].wr);
                if (VECS[i].wr) chk($sformatf("R7 wdata v%0d", i), mem_wdata, VECS[i].wd);
                if (VECS[i].byt) chk($sformatf("R10 no trap byte v%0d", i), trap, 0);
            end
            if (VECS[i].rwe) chk($sformatf("R3 R4 wb_val v%0d", i), reg_wb_val, VECS[i].rnew);
            @(negedge clk);
            chk($sformatf("R8 rd_valid v%0d", i), rd_valid, !VECS[i].trp && !VECS[i].wr);
            chk($sformatf("R8 rd_data v%0d", i), rd_data,
                (!VECS[i].trp && !VECS[i].wr) ? VECS[i].rd : 16'h0000);
            chk($sformatf("R5 trap one cycle v%0d", i), trap, 0);
        end

        // R9: back-to-back requests, each one cycle later
        drive(3'd1, 1'b0, 1'b0, 16'h0100, 16'h0);
        @(negedge clk);
        chk("R9 b2b first ea", mem_addr, 16'h0100);
        chk("R3 b2b first wb", reg_wb_val, 16'h0102);
        drive(3'd2, 1'b1, 1'b1, 16'h0101, 16'h005A);
        mem_rdata = 16'h9876;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R8 b2b first rd", rd_data, 16'h9876);
        chk("R9 b2b second ea", mem_addr, 16'h0101);
        chk("R3 b2b second wb", reg_wb_val, 16'h0100);
        chk("R7 b2b second wdata", mem_wdata, 16'h5A5A);
        @(negedge clk);
        chk("R8 no rd after write", rd_valid, 0);
        chk("R9 idle after b2b", mem_strobe, 0);

        // R1: reset together with a request clears the outputs
        drive(3'd1, 1'b0, 1'b0, 16'h0200, 16'h0);
        rst = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R1 reset beats request strobe", mem_strobe, 0);
        chk("R1 reset beats request wb", reg_wb_en, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after reset rd_valid", rd_valid, 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule